// File: doc/BRIEF.md
# Next Instruction Address Unit

This block works out the address of the next instruction for a machine whose instructions are 32-bit words at byte addresses. It takes the current program counter, the fetched instruction word, a register operand, and a one-bit condition result from an outside comparator. It returns the next program counter, a link address and a write strobe for the link register. The block is purely combinational, so it can sit in the fetch stage between the PC register and the instruction memory address.

It handles five kinds of control flow: straight-line flow, conditional branches relative to the PC, jumps within the current 256 MB region, calls that also save a return address, and jumps through a register. The block does not access the register file, does not evaluate conditions, and has no exceptions or delay slots.

Top module: `npc_unit`

## Requirements
- R1: For any opcode (bits 31:26) other than 2, 3, 4, 5, 6 or 7, and other than opcode 0 with function code 8, next_pc_o equals pc_i + 4 (modulo 2^32), so 0xFFFFFFFC wraps to 0x00000000.
- R2: For branch opcodes 4, 5, 6 and 7 with cond_i = 1, next_pc_o equals pc_i + 4 + (sign-extended bits 15:0 of the instruction shifted left by 2). With cond_i = 0, next_pc_o equals pc_i + 4.
- R3: A branch offset with bit 15 set moves the target backwards. Offset 0xFFFF gives pc_i, and offset 0x8000 gives pc_i + 4 - 0x20000.
- R4: For opcode 2, next_pc_o is {bits 31:28 of pc_i + 4, bits 25:0 of the instruction, 2'b00}. The upper nibble comes from pc_i + 4, not from pc_i.
- R5: Opcode 3 forms the same target as opcode 2 and asserts link_we_o. link_we_o is 0 for every other instruction.
- R6: Opcode 0 with function code 8 (bits 5:0) sets next_pc_o to reg_i unmodified, including its low two bits.
- R7: cond_i has no effect on any output unless the opcode is 4, 5, 6 or 7.
- R8: link_addr_o always equals pc_i + 4, and link_idx_o is always 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current program counter |
| instr_i | input | 32 | Fetched instruction word |
| reg_i | input | 32 | Register operand for register-indirect jumps |
| cond_i | input | 1 | Branch condition result, 1 = take |
| next_pc_o | output | 32 | Next program counter |
| link_addr_o | output | 32 | Return address (pc_i + 4) |
| link_idx_o | output | 5 | Return-address register index (31) |
| link_we_o | output | 1 | Link register write strobe, call only |

## Verification
The alignment assertion assumes that pc_i is word-aligned. For that reason the bench drives random PCs with the low two bits cleared, and it sends unaligned values only through reg_i. The assertions are evaluated only when all inputs are known, so the undriven inputs at time zero are not checked. The random opcode mix gives extra weight to opcodes 0 to 7 and to function code 8 so that each control-flow kind occurs often. Directed cases cover region-boundary crossing, address wraparound, and offsets at the extremes of their range.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned OPC_W     = 6;
  localparam int unsigned FN_W      = 6;
  localparam int unsigned REG_IDX_W = 5;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0] OPC_J       = 6'd2;
  localparam logic [OPC_W-1:0] OPC_JAL     = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BR_LO   = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BR_HI   = 6'd7;
  localparam logic [FN_W-1:0]  FN_JR       = 6'd8;

  typedef enum logic [2:0] {
    NK_SEQ,
    NK_BRANCH,
    NK_JUMP,
    NK_CALL,
    NK_REG
  } npc_kind_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] instr_i,
  output npc_kind_e       kind_o
);
  localparam int unsigned OPC_LSB = XLEN - OPC_W;

  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;

  assign opc = instr_i[XLEN-1:OPC_LSB];
  assign fn  = instr_i[FN_W-1:0];

  always_comb begin
    kind_o = NK_SEQ;
    if (opc == OPC_J)                              kind_o = NK_JUMP;
    else if (opc == OPC_JAL)                       kind_o = NK_CALL;
    else if (opc >= OPC_BR_LO && opc <= OPC_BR_HI) kind_o = NK_BRANCH;
    else if (opc == OPC_SPECIAL && fn == FN_JR)    kind_o = NK_REG;
  end
endmodule

// File: rtl/npc_branch_adder.sv
module npc_branch_adder #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 16
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int unsigned EXT_W = XLEN - OFF_W - 2;

  logic [XLEN-1:0] disp;

  // word offset -> signed byte displacement
  assign disp     = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
  assign target_o = base_i + disp;
endmodule

// File: rtl/npc_jump_former.sv
module npc_jump_former #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IDX_W = 26
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int unsigned REGION_LSB = IDX_W + 2;

  // region bits from the sequential address, word index below
  assign target_o = {base_i[XLEN-1:REGION_LSB], idx_i, 2'b00};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned OFF_W       = 16,
  parameter int unsigned IDX_W       = 26,
  parameter int unsigned INSTR_BYTES = 4,
  parameter int unsigned RA_INDEX    = 31
) (
  input  logic [XLEN-1:0]      pc_i,
  input  logic [XLEN-1:0]      instr_i,
  input  logic [XLEN-1:0]      reg_i,
  input  logic                 cond_i,
  output logic [XLEN-1:0]      next_pc_o,
  output logic [XLEN-1:0]      link_addr_o,
  output logic [REG_IDX_W-1:0] link_idx_o,
  output logic                 link_we_o
);
  localparam int unsigned  OPC_LSB = XLEN - OPC_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  npc_kind_e       kind;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;

  assign seq_pc = pc_i + STEP;

  npc_decode #(.XLEN(XLEN)) u_decode (
    .instr_i (instr_i),
    .kind_o  (kind)
  );

  npc_branch_adder #(.XLEN(XLEN), .OFF_W(OFF_W)) u_branch (
    .base_i   (seq_pc),
    .off_i    (instr_i[OFF_W-1:0]),
    .target_o (br_target)
  );

  npc_jump_former #(.XLEN(XLEN), .IDX_W(IDX_W)) u_jump (
    .base_i   (seq_pc),
    .idx_i    (instr_i[IDX_W-1:0]),
    .target_o (jmp_target)
  );

  always_comb begin
    unique case (kind)
      NK_BRANCH: next_pc_o = cond_i ? br_target : seq_pc;
      NK_JUMP,
      NK_CALL:   next_pc_o = jmp_target;
      NK_REG:    next_pc_o = reg_i;
      default:   next_pc_o = seq_pc;
    endcase
  end

  assign link_addr_o = seq_pc;
  assign link_idx_o  = REG_IDX_W'(RA_INDEX);
  assign link_we_o   = (kind == NK_CALL);

  always_comb begin
    if (!$isunknown({pc_i, instr_i, reg_i, cond_i})) begin
      p_seq_step_r1: assert (kind != NK_SEQ || next_pc_o == pc_i + STEP)
        else $error("sequential step wrong");
      p_untaken_r2: assert (!(kind == NK_BRANCH && !cond_i) || next_pc_o == link_addr_o)
        else $error("untaken branch did not fall through");
      p_region_r4: assert (!(kind == NK_JUMP || kind == NK_CALL)
                           || next_pc_o[XLEN-1:IDX_W+2] == link_addr_o[XLEN-1:IDX_W+2])
        else $error("jump left region");
      p_link_call_r5: assert (link_we_o == (instr_i[XLEN-1:OPC_LSB] == OPC_JAL))
        else $error("link strobe mismatch");
      p_reg_pass_r6: assert (kind != NK_REG || next_pc_o == reg_i)
        else $error("register jump altered operand");
      p_aligned_r8: assert (kind == NK_REG || pc_i[1:0] != 2'b00 || next_pc_o[1:0] == 2'b00)
        else $error("misaligned next pc");
    end
  end
endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
  logic        clk = 1'b0;
  logic [31:0] pc, ins, rg;
  logic        cond;
  logic [31:0] next_pc, link_addr;
  logic [4:0]  link_idx;
  logic        link_we;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  npc_unit u_dut (
    .pc_i(pc), .instr_i(ins), .reg_i(rg), .cond_i(cond),
    .next_pc_o(next_pc), .link_addr_o(link_addr),
    .link_idx_o(link_idx), .link_we_o(link_we)
  );

  function automatic logic [31:0] exp_next(logic [31:0] p, logic [31:0] i,
                                           logic [31:0] r, logic c);
    logic [5:0]  op = i[31:26];
    logic [31:0] s  = p + 32'd4;
    if (op == 6'd2 || op == 6'd3) return {s[31:28], i[25:0], 2'b00};
    if (op >= 6'd4 && op <= 6'd7)
      return c ? s + {{14{i[15]}}, i[15:0], 2'b00} : s;
    if (op == 6'd0 && i[5:0] == 6'd8) return r;
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] p, logic [31:0] i, logic [31:0] r, logic c);
    @(negedge clk);
    pc = p; ins = i; rg = r; cond = c;
    #1;
  endtask

  task automatic full(string tag, logic [31:0] p, logic [31:0] i, logic [31:0] r, logic c);
    apply(p, i, r, c);
    chk({tag, " next"}, next_pc, exp_next(p, i, r, c));
    chk("R8 link_addr", link_addr, p + 32'd4);
    chk("R8 link_idx", {27'd0, link_idx}, 32'd31);
    chk("R5 link_we", {31'd0, link_we}, {31'd0, i[31:26] == 6'd3});
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    pc = 0; ins = 0; rg = 0; cond = 0;
    // R1 reset-like state: nop at zero
    apply(32'h0, 32'h0, 32'h0, 1'b0);
    chk("R1 nop at 0", next_pc, 32'h4);
    chk("R5 idle strobe", {31'd0, link_we}, 32'd0);
    // R1 wraparound
    apply(32'hFFFF_FFFC, 32'h2000_0000, 32'h0, 1'b1);
    chk("R1 wrap", next_pc, 32'h0);
    // R2 taken forward, untaken
    apply(32'h0000_1000, 32'h1000_0010, 32'h0, 1'b1);
    chk("R2 beq taken", next_pc, 32'h0000_1044);
    apply(32'h0000_1000, 32'h1400_0010, 32'h0, 1'b0);
    chk("R2 bne untaken", next_pc, 32'h0000_1004);
    apply(32'h0000_1000, 32'h1C00_0001, 32'h0, 1'b1);
    chk("R2 bgtz taken", next_pc, 32'h0000_1008);
    // R3 backward
    apply(32'h0000_1000, 32'h1800_FFFF, 32'h0, 1'b1);
    chk("R3 offset -1", next_pc, 32'h0000_1000);
    apply(32'h0004_0000, 32'h1000_8000, 32'h0, 1'b1);
    chk("R3 offset min", next_pc, 32'h0002_0004);
    // R4 jump region from pc+4
    apply(32'h0FFF_FFFC, 32'h0800_0001, 32'h0, 1'b0);
    chk("R4 region crossing", next_pc, 32'h1000_0004);
    apply(32'hA000_0000, 32'h0BFF_FFFF, 32'h0, 1'b0);
    chk("R4 max index", next_pc, 32'hAFFF_FFFC);
    // R5 call
    apply(32'h0040_0004, 32'h0C10_0040, 32'h0, 1'b0);
    chk("R5 call target", next_pc, 32'h0040_0100);
    chk("R5 call strobe", {31'd0, link_we}, 32'd1);
    chk("R5 call link", link_addr, 32'h0040_0008);
    // R6 register jump, unaligned kept
    apply(32'h0000_2000, 32'h03E0_0008, 32'h1234_5677, 1'b0);
    chk("R6 jr passthru", next_pc, 32'h1234_5677);
    chk("R6 jr no strobe", {31'd0, link_we}, 32'd0);
    // R1 other funct under opcode 0
    apply(32'h0000_2000, 32'h0000_0009, 32'hDEAD_BEEF, 1'b1);
    chk("R1 opc0 funct9", next_pc, 32'h0000_2004);
    // R7 cond ignored for non-branch
    apply(32'h0000_3000, 32'h8C00_0010, 32'h0, 1'b1);
    chk("R7 load cond=1", next_pc, 32'h0000_3004);
    apply(32'h0000_3000, 32'h0800_0010, 32'h0, 1'b1);
    chk("R7 jump cond=1", next_pc, 32'h0000_0040);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] p, i, r;
      logic [5:0]  op;
      p = $urandom() & 32'hFFFF_FFFC;
      i = $urandom();
      r = $urandom();
      op = ($urandom_range(0, 3) == 0) ? 6'($urandom()) : 6'($urandom_range(0, 7));
      i[31:26] = op;
      if (op == 6'd0 && $urandom_range(0, 1) == 1) i[5:0] = 6'd8;
      full("R2 R4 R6 random", p, i, r, 1'($urandom()));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule